// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block watches two reference clocks and judges each one against a feedback clock, which also clocks all of its state. Over a fixed window of feedback cycles it counts the rising edges of each reference, after a two-flop synchronizer. When a count falls outside an allowed band around the expected value, that reference gets a bad flag. The flag stays set until it is cleared. A select output tells a downstream clock multiplexer which reference to use. If the reference in use is flagged and the other one is still healthy, the block moves the selection to the other reference on its own.

A low-going alarm-clear input clears both flags and aligns the selection with a user select pin. It acts once per falling edge, however long it stays low. A manual override input turns off automatic switching, so the selection simply follows the user select pin. A bypass request is synchronized and passed through as a mode flag. An active-low asynchronous master reset clears all state and drives every output low.

Top module: `refclk_failover`

## Requirements
- R1: At the end of each window of WIN_CYCLES feedback cycles, a reference whose rising-edge count lies below EXP_EDGES-TOL_EDGES has its bad flag (active high) set; a stopped reference is therefore flagged.
- R2: A bad flag, once set, stays high until an alarm-clear event.
- R3: A falling edge on alarm_clr_n clears both bad flags and loads sel_ref with user_sel.
- R4: Holding alarm_clr_n low produces a single clear event; a reference that fails while the input is still low gets flagged again.
- R5: With override low, if the reference named by sel_ref is flagged and the other is not, sel_ref inverts on the next feedback cycle.
- R6: With override high, sel_ref follows user_sel (after synchronization), and no automatic switch occurs.
- R7: With override low and no clear event, changing user_sel does not move sel_ref.
- R8: While rst_n is low, ref0_bad, ref1_bad, sel_ref and bypass_mode are all low, taking effect asynchronously.
- R9: bypass_mode follows bypass_en after a two-flop synchronizer.
- R10: When both references are flagged, sel_ref holds its value.
- R11: A reference whose rising-edge count in a window exceeds EXP_EDGES+TOL_EDGES is flagged bad.
- R12: sel_ref encoding: 0 selects reference 0, 1 selects reference 1; user_sel uses the same encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fb_clk | input | 1 | Feedback clock, clocks all state |
| rst_n | input | 1 | Asynchronous master reset, active low |
| ref0_in | input | 1 | Reference clock 0, sampled as data |
| ref1_in | input | 1 | Reference clock 1, sampled as data |
| alarm_clr_n | input | 1 | Alarm clear, acts on its falling edge |
| user_sel | input | 1 | User reference choice (0 = ref 0) |
| override | input | 1 | High disables automatic switching |
| bypass_en | input | 1 | Bypass mode request |
| ref0_bad | output | 1 | Sticky bad flag for reference 0 |
| ref1_bad | output | 1 | Sticky bad flag for reference 1 |
| sel_ref | output | 1 | Selected reference (0 or 1) |
| bypass_mode | output | 1 | Synchronized bypass flag |

## Verification
The assertions assume that each reference toggles slower than half the feedback rate, so the synchronized copy shows every edge. They also assume that the control inputs stay steady for several feedback cycles around each change. The bench generates references with periods of four and two feedback cycles, and it places their edges midway between feedback edges. It holds every control level for at least four cycles. Scenarios that reconnect a reference wait more than two full windows before clearing the flags, so no partly filled window can set a flag again after the clear.

// File: rtl/rfo_pkg.sv
package rfo_pkg;
  // True when an edge total lies inside the accepted band.
  function automatic bit edge_count_ok(input int total, input int exp_e, input int tol);
    return (total >= exp_e - tol) && (total <= exp_e + tol);
  endfunction
endpackage

// File: rtl/rfo_sync.sv
module rfo_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rfo_window.sv
module rfo_window #(
  parameter int unsigned WIN_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  localparam int unsigned WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  logic [WW-1:0] cnt;
  assign win_end = (cnt == WW'(WIN_CYCLES - 1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (win_end) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfo_ref_mon.sv
module rfo_ref_mon
  import rfo_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 16,
  parameter int unsigned EXP_EDGES  = 4,
  parameter int unsigned TOL_EDGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic win_end,
  input  logic clear,
  output logic bad
);
  localparam int unsigned CW = $clog2(WIN_CYCLES + 1);

  logic          ref_s, ref_prev, rise;
  logic [CW-1:0] edge_cnt;
  logic          window_ok;

  rfo_sync #(.W(1), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ref_in), .q(ref_s)
  );

  assign rise      = ref_s & ~ref_prev;
  assign window_ok = edge_count_ok(int'(edge_cnt) + int'(rise),
                                   int'(EXP_EDGES), int'(TOL_EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_prev <= 1'b0;
      edge_cnt <= '0;
      bad      <= 1'b0;
    end else begin
      ref_prev <= ref_s;
      edge_cnt <= win_end ? '0 : edge_cnt + {{(CW-1){1'b0}}, rise};
      if (clear)                     bad <= 1'b0;
      else if (win_end && !window_ok) bad <= 1'b1;
    end
  end
endmodule

// File: rtl/rfo_select.sv
module rfo_select (
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_pulse,
  input  logic override_s,
  input  logic user_sel_s,
  input  logic bad0,
  input  logic bad1,
  output logic sel
);
  logic cur_bad, other_bad;
  assign cur_bad   = sel ? bad1 : bad0;
  assign other_bad = sel ? bad0 : bad1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sel <= 1'b0;
    else if (alarm_pulse || override_s) sel <= user_sel_s;
    else if (cur_bad && !other_bad)   sel <= ~sel;
  end
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover #(
  parameter int unsigned WIN_CYCLES = 16,
  parameter int unsigned EXP_EDGES  = 4,
  parameter int unsigned TOL_EDGES  = 2
) (
  input  logic fb_clk,
  input  logic rst_n,
  input  logic ref0_in,
  input  logic ref1_in,
  input  logic alarm_clr_n,
  input  logic user_sel,
  input  logic override,
  input  logic bypass_en,
  output logic ref0_bad,
  output logic ref1_bad,
  output logic sel_ref,
  output logic bypass_mode
);
  logic [3:0] ctrl_s;
  logic       alarm_s, alarm_prev, alarm_pulse;
  logic       user_sel_s, override_s, win_end;
  logic [1:0] ref_v, bad_v;

  rfo_sync #(.W(4), .RST_VAL(4'b1000)) u_ctrl_sync (
    .clk(fb_clk), .rst_n(rst_n),
    .d({alarm_clr_n, user_sel, override, bypass_en}), .q(ctrl_s)
  );
  assign alarm_s     = ctrl_s[3];
  assign user_sel_s  = ctrl_s[2];
  assign override_s  = ctrl_s[1];
  assign bypass_mode = ctrl_s[0];

  // Falling-edge one-shot of the synchronized alarm clear.
  always_ff @(posedge fb_clk or negedge rst_n) begin
    if (!rst_n) alarm_prev <= 1'b1;
    else        alarm_prev <= alarm_s;
  end
  assign alarm_pulse = alarm_prev & ~alarm_s;

  rfo_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk(fb_clk), .rst_n(rst_n), .win_end(win_end)
  );

  assign ref_v = {ref1_in, ref0_in};
  for (genvar gi = 0; gi < 2; gi++) begin : g_mon
    rfo_ref_mon #(
      .WIN_CYCLES(WIN_CYCLES), .EXP_EDGES(EXP_EDGES), .TOL_EDGES(TOL_EDGES)
    ) u_mon (
      .clk(fb_clk), .rst_n(rst_n), .ref_in(ref_v[gi]),
      .win_end(win_end), .clear(alarm_pulse), .bad(bad_v[gi])
    );
  end
  assign ref0_bad = bad_v[0];
  assign ref1_bad = bad_v[1];

  rfo_select u_select (
    .clk(fb_clk), .rst_n(rst_n), .alarm_pulse(alarm_pulse),
    .override_s(override_s), .user_sel_s(user_sel_s),
    .bad0(bad_v[0]), .bad1(bad_v[1]), .sel(sel_ref)
  );
endmodule

// File: rtl/rfo_checker.sv
module rfo_checker (
  input logic fb_clk,
  input logic rst_n,
  input logic win_end,
  input logic alarm_pulse,
  input logic user_sel_s,
  input logic override_s,
  input logic ref0_bad,
  input logic ref1_bad,
  input logic sel_ref,
  input logic bypass_mode
);
  assert_flag_at_window_R1: assert property (@(posedge fb_clk) disable iff (!rst_n)
    ($rose(ref0_bad) || $rose(ref1_bad)) |-> $past(win_end));

  assert_flag0_sticky_R2: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (ref0_bad && !alarm_pulse) |=> ref0_bad);

  assert_flag1_sticky_R2: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (ref1_bad && !alarm_pulse) |=> ref1_bad);

  assert_clear_aligns_R3: assert property (@(posedge fb_clk) disable iff (!rst_n)
    alarm_pulse |=> (!ref0_bad && !ref1_bad && sel_ref == $past(user_sel_s)));

  assert_single_pulse_R4: assert property (@(posedge fb_clk) disable iff (!rst_n)
    alarm_pulse |=> !alarm_pulse);

  assert_auto_switch_R5: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (!override_s && !alarm_pulse && (sel_ref ? (ref1_bad && !ref0_bad) : (ref0_bad && !ref1_bad)))
    |=> sel_ref != $past(sel_ref));

  assert_override_follows_R6: assert property (@(posedge fb_clk) disable iff (!rst_n)
    override_s |=> sel_ref == $past(user_sel_s));

  assert_no_spurious_move_R7: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (!override_s && !alarm_pulse && !ref0_bad && !ref1_bad) |=> $stable(sel_ref));

  assert_reset_low_R8: assert property (@(posedge fb_clk)
    !rst_n |-> (!ref0_bad && !ref1_bad && !sel_ref && !bypass_mode));

  assert_both_bad_hold_R10: assert property (@(posedge fb_clk) disable iff (!rst_n)
    (!override_s && !alarm_pulse && ref0_bad && ref1_bad) |=> $stable(sel_ref));
endmodule

bind refclk_failover rfo_checker u_rfo_checker (
  .fb_clk(fb_clk), .rst_n(rst_n), .win_end(win_end), .alarm_pulse(alarm_pulse),
  .user_sel_s(user_sel_s), .override_s(override_s), .ref0_bad(ref0_bad),
  .ref1_bad(ref1_bad), .sel_ref(sel_ref), .bypass_mode(bypass_mode)
);

// File: tb/refclk_failover_test.sv
`timescale 1ns/1ps
module refclk_failover_test;
  logic fb_clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref0_in = 1'b0, ref1_in = 1'b0;
  logic alarm_clr_n = 1'b1, user_sel = 1'b0, override = 1'b0, bypass_en = 1'b0;
  logic ref0_bad, ref1_bad, sel_ref, bypass_mode;

  logic ref0_en = 1'b1, ref1_en = 1'b1;
  int   ref0_half = 20, ref1_half = 20;
  int   n_checks = 0, n_fail = 0;
  bit   done = 1'b0;

  refclk_failover uut (
    .fb_clk(fb_clk), .rst_n(rst_n), .ref0_in(ref0_in), .ref1_in(ref1_in),
    .alarm_clr_n(alarm_clr_n), .user_sel(user_sel), .override(override),
    .bypass_en(bypass_en), .ref0_bad(ref0_bad), .ref1_bad(ref1_bad),
    .sel_ref(sel_ref), .bypass_mode(bypass_mode)
  );

  always #5 fb_clk = ~fb_clk;  // 100 MHz; rising edges at 5, 15, 25 ns ...
  // Reference edges fall on multiples of 10 ns, midway between feedback edges.
  always begin #(ref0_half); if (ref0_en) ref0_in = ~ref0_in; end
  always begin #(ref1_half); if (ref1_en) ref1_in = ~ref1_in; end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge fb_clk);
    #2;
  endtask

  task automatic alarm_event();
    alarm_clr_n = 1'b0; cycles(6);
    alarm_clr_n = 1'b1; cycles(4);
  endtask

  task automatic t_reset();
    #1;
    check("R8 reset ref0_bad", ref0_bad, 1'b0);
    check("R8 reset sel_ref", sel_ref, 1'b0);
    cycles(3); rst_n = 1'b1;
    cycles(50);
    check("R1 healthy ref0 not flagged", ref0_bad, 1'b0);
    check("R1 healthy ref1 not flagged", ref1_bad, 1'b0);
    check("R12 sel_ref idle on ref 0", sel_ref, 1'b0);
  endtask

  task automatic t_bypass();
    bypass_en = 1'b1; cycles(4);
    check("R9 bypass on", bypass_mode, 1'b1);
    bypass_en = 1'b0; cycles(4);
    check("R9 bypass off", bypass_mode, 1'b0);
  endtask

  task automatic t_fail_switch();
    ref0_en = 1'b0; cycles(50);
    check("R1 stopped ref0 flagged", ref0_bad, 1'b1);
    check("R1 ref1 stays good", ref1_bad, 1'b0);
    check("R5 switched to ref 1", sel_ref, 1'b1);
  endtask

  task automatic t_sticky_ignore();
    ref0_en = 1'b1; cycles(50);
    check("R2 flag persists after recovery", ref0_bad, 1'b1);
    user_sel = 1'b0; cycles(10);
    check("R7 user_sel ignored without override", sel_ref, 1'b1);
  endtask

  task automatic t_clear_once();
    user_sel = 1'b0; alarm_clr_n = 1'b0; cycles(6);
    check("R3 clear ref0_bad", ref0_bad, 1'b0);
    check("R3 clear ref1_bad", ref1_bad, 1'b0);
    check("R3 sel aligned to user_sel", sel_ref, 1'b0);
    ref0_en = 1'b0; cycles(50);
    check("R4 held-low clear acts once", ref0_bad, 1'b1);
    check("R5 switch while clear held", sel_ref, 1'b1);
    alarm_clr_n = 1'b1; ref0_en = 1'b1; cycles(40);
    alarm_event();
    check("R3 second clear ref0_bad", ref0_bad, 1'b0);
    check("R3 second clear sel", sel_ref, 1'b0);
  endtask

  task automatic t_override();
    override = 1'b1; cycles(4);
    ref0_en = 1'b0; cycles(50);
    check("R1 ref0 flagged under override", ref0_bad, 1'b1);
    check("R6 no auto switch under override", sel_ref, 1'b0);
    user_sel = 1'b1; cycles(5);
    check("R6 follows user_sel high", sel_ref, 1'b1);
    user_sel = 1'b0; cycles(5);
    check("R6 follows user_sel low", sel_ref, 1'b0);
    override = 1'b0; cycles(5);
    check("R5 auto switch after override drops", sel_ref, 1'b1);
    ref0_en = 1'b1; cycles(40);
  endtask

  task automatic t_both_bad();
    ref1_en = 1'b0; cycles(50);
    check("R10 ref1 flagged", ref1_bad, 1'b1);
    check("R10 ref0 still flagged", ref0_bad, 1'b1);
    check("R10 sel held with both bad", sel_ref, 1'b1);
    ref1_en = 1'b1; cycles(40);
    user_sel = 1'b0; alarm_event();
    check("R3 clear after both bad", ref1_bad, 1'b0);
    check("R3 sel back to ref 0", sel_ref, 1'b0);
  endtask

  task automatic t_fast();
    ref1_half = 10; cycles(50);
    check("R11 fast ref1 flagged", ref1_bad, 1'b1);
    check("R11 ref0 unaffected", ref0_bad, 1'b0);
    check("R11 sel stays on good ref 0", sel_ref, 1'b0);
    ref1_half = 20; cycles(10);
  endtask

  task automatic t_master_reset();
    bypass_en = 1'b1; cycles(4);
    rst_n = 1'b0; #1;
    check("R8 async reset ref1_bad", ref1_bad, 1'b0);
    check("R8 async reset bypass_mode", bypass_mode, 1'b0);
    check("R8 async reset sel_ref", sel_ref, 1'b0);
    cycles(2); rst_n = 1'b1; bypass_en = 1'b0; cycles(2);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_fail_switch();
    t_sticky_ignore();
    t_clear_once();
    t_override();
    t_both_bad();
    t_fast();
    t_master_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule